// File: doc/BRIEF.md
# DRAM Chip-Select Window Decoder

This block maps a 32-bit CPU physical address onto one of a small set of SDRAM chip-select windows. Software programs each window through a word-wide register port: a base register gives the window start in 16 MiB steps, and a size register gives the window length and the enable bit. The base register also has a few extended high address bits. A window that sets any of them lies above the 4 GiB line, so a 32-bit lookup never reaches it.

The lookup port is combinational. For a presented address it returns a hit flag, the index of the chip select that claims the address, and an attribute code for that chip select. The attribute is active-low one-hot: it is all ones with the bit of the chip select cleared.

A second set of outputs lists the windows that a DMA master limited to 32-bit addresses can use. These are the enabled windows whose extended bits are all zero. The list is packed toward entry 0 in ascending chip-select order, and a count of the entries comes with it. Each entry gives the original chip-select index, the byte base, the byte size and the attribute.

Top module: `memwin_decoder`

## Requirements
- R1: After reset, every register reads zero, no lookup hits and the DMA entry count is zero.
- R2: Window n is programmed through two word offsets. Its base register is at byte offset n*8 and its size register is at n*8+4. A write takes effect on the clock edge that samples it, and a read returns the value combinationally.
- R3: Base register bits 31:24 (base field) and 3:0 (extended bits) are stored. Size register bits 31:24 (size field) and bit 0 (enable) are stored. All other bits read as zero.
- R4: An address hits window n when all three of these hold: the window is enabled, its extended bits are zero, and (addr[31:24] AND NOT size field) equals the base field.
- R5: A window whose enable bit is 0 never hits and never appears in the DMA list.
- R6: When several windows match the same address, the lowest chip-select index is reported.
- R7: On a hit, the attribute is 4'hF with bit cs cleared. On a miss, the chip-select index and the attribute are both zero.
- R8: The DMA list holds exactly the enabled windows whose extended bits are zero. They are packed from entry 0 in ascending chip-select order, and the count equals the number of such windows.
- R9: Each DMA entry carries four values: the chip-select index; the base as {base field, 24'h0}; the size as the 33-bit value {size field, 24'hFFFFFF}+1, so a size field of 8'hFF gives 33'h1_0000_0000; and the attribute of R7. Entries at or above the count are all zero.
- R10: A window with nonzero extended bits neither hits nor enters the DMA list, even when it is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register byte offset (bits 1:0 ignored) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| lk_addr | input | 32 | Address to decode |
| lk_hit | output | 1 | Address falls in a usable window |
| lk_cs | output | 2 | Chip-select index of the hit |
| lk_attr | output | 4 | Active-low one-hot attribute of the hit |
| dma_count | output | 3 | Number of DMA-visible windows |
| dma_cs | output | 8 | Packed chip-select indices, entry k at [2k+1:2k] |
| dma_base | output | 128 | Packed byte bases, entry k at [32k+31:32k] |
| dma_size | output | 132 | Packed byte sizes, entry k at [33k+32:33k] |
| dma_attr | output | 16 | Packed attributes, entry k at [4k+3:4k] |

## Verification
The bench builds the decoder with its default of four windows and a 16 MiB step. With these values every chip select and every attribute code is exercised. The DMA list can be filled completely, partially, or with a gap left by an excluded window. A size field of 8'hFF makes the size calculation carry into bit 32. Overlapping windows and windows disabled after use are also covered, so priority and exclusion are each tested on their own.

// File: rtl/memwin_pkg.sv
package memwin_pkg;

    localparam int MW_ADDR_W = 32;               // CPU address and register width
    localparam int MW_GRAN   = 24;               // log2 of the window step (16 MiB)
    localparam int MW_FLD_W  = MW_ADDR_W - MW_GRAN;
    localparam int MW_EXT_W  = 4;                // extended high address bits
    localparam int MW_SPAN_W = MW_ADDR_W + 1;    // size may reach 4 GiB

    typedef struct packed {
        logic [MW_FLD_W-1:0] base_f;
        logic [MW_EXT_W-1:0] ext;
        logic [MW_FLD_W-1:0] size_f;
        logic                en;
    } win_cfg_t;

    // A window is reachable by 32-bit masters only when enabled and low.
    function automatic logic win_usable(input win_cfg_t w);
        return w.en && (w.ext == '0);
    endfunction

    function automatic logic [MW_ADDR_W-1:0] win_base_bytes(input win_cfg_t w);
        return {w.base_f, {MW_GRAN{1'b0}}};
    endfunction

    function automatic logic [MW_SPAN_W-1:0] win_span_bytes(input win_cfg_t w);
        return {1'b0, w.size_f, {MW_GRAN{1'b1}}} + MW_SPAN_W'(1);
    endfunction

    // Bits that survive a write, per register kind.
    function automatic logic [MW_ADDR_W-1:0] reg_mask(input logic is_size);
        logic [MW_ADDR_W-1:0] m;
        m = '0;
        m[MW_ADDR_W-1:MW_GRAN] = '1;
        if (is_size) m[0] = 1'b1;
        else         m[MW_EXT_W-1:0] = '1;
        return m;
    endfunction

endpackage

// File: rtl/memwin_regs.sv
module memwin_regs
    import memwin_pkg::*;
#(
    parameter int NUM_WIN = 4,
    localparam int IDX_W  = $clog2(NUM_WIN),
    localparam int OFF_W  = IDX_W + 3
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cfg_we,
    input  logic [OFF_W-1:0]             cfg_addr,
    input  logic [MW_ADDR_W-1:0]         cfg_wdata,
    output logic [MW_ADDR_W-1:0]         cfg_rdata,
    output win_cfg_t [NUM_WIN-1:0]       win
);

    logic [IDX_W-1:0] sel_idx;
    logic             sel_size;

    assign sel_idx  = cfg_addr[OFF_W-1:3];
    assign sel_size = cfg_addr[2];

    always_ff @(posedge clk) begin
        if (rst) begin
            win <= '0;
        end else if (cfg_we && (32'(sel_idx) < NUM_WIN)) begin
            if (sel_size) begin
                win[sel_idx].size_f <= cfg_wdata[MW_ADDR_W-1:MW_GRAN];
                win[sel_idx].en     <= cfg_wdata[0];
            end else begin
                win[sel_idx].base_f <= cfg_wdata[MW_ADDR_W-1:MW_GRAN];
                win[sel_idx].ext    <= cfg_wdata[MW_EXT_W-1:0];
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (32'(sel_idx) < NUM_WIN) begin
            if (sel_size) begin
                cfg_rdata[MW_ADDR_W-1:MW_GRAN] = win[sel_idx].size_f;
                cfg_rdata[0]                   = win[sel_idx].en;
            end else begin
                cfg_rdata[MW_ADDR_W-1:MW_GRAN] = win[sel_idx].base_f;
                cfg_rdata[MW_EXT_W-1:0]        = win[sel_idx].ext;
            end
        end
    end

endmodule

// File: rtl/memwin_match.sv
module memwin_match
    import memwin_pkg::*;
#(
    parameter int NUM_WIN = 4,
    localparam int IDX_W  = $clog2(NUM_WIN)
) (
    input  win_cfg_t [NUM_WIN-1:0]  win,
    input  logic [MW_ADDR_W-1:0]    lk_addr,
    output logic                    lk_hit,
    output logic [IDX_W-1:0]        lk_cs,
    output logic [NUM_WIN-1:0]      lk_attr
);

    logic [NUM_WIN-1:0] hit_vec;

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
        assign hit_vec[g] = win_usable(win[g]) &&
            ((lk_addr[MW_ADDR_W-1:MW_GRAN] & ~win[g].size_f) == win[g].base_f);
    end

    // Scan from the top so the lowest matching index is left in place.
    always_comb begin
        lk_hit  = 1'b0;
        lk_cs   = '0;
        lk_attr = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                lk_hit  = 1'b1;
                lk_cs   = IDX_W'(i);
                lk_attr = ~(NUM_WIN'(1) << i);
            end
        end
    end

endmodule

// File: rtl/memwin_pack.sv
module memwin_pack
    import memwin_pkg::*;
#(
    parameter int NUM_WIN = 4,
    localparam int IDX_W  = $clog2(NUM_WIN),
    localparam int CNT_W  = $clog2(NUM_WIN + 1)
) (
    input  win_cfg_t [NUM_WIN-1:0]           win,
    output logic [CNT_W-1:0]                 dma_count,
    output logic [NUM_WIN*IDX_W-1:0]         dma_cs,
    output logic [NUM_WIN*MW_ADDR_W-1:0]     dma_base,
    output logic [NUM_WIN*MW_SPAN_W-1:0]     dma_size,
    output logic [NUM_WIN*NUM_WIN-1:0]       dma_attr
);

    always_comb begin
        int k;
        k         = 0;
        dma_cs    = '0;
        dma_base  = '0;
        dma_size  = '0;
        dma_attr  = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (win_usable(win[i])) begin
                dma_cs[k*IDX_W +: IDX_W]           = IDX_W'(i);
                dma_base[k*MW_ADDR_W +: MW_ADDR_W] = win_base_bytes(win[i]);
                dma_size[k*MW_SPAN_W +: MW_SPAN_W] = win_span_bytes(win[i]);
                dma_attr[k*NUM_WIN +: NUM_WIN]     = ~(NUM_WIN'(1) << i);
                k = k + 1;
            end
        end
        dma_count = CNT_W'(k);
    end

endmodule

// File: rtl/memwin_decoder.sv
module memwin_decoder
    import memwin_pkg::*;
#(
    parameter int NUM_WIN = 4,
    localparam int IDX_W  = $clog2(NUM_WIN),
    localparam int OFF_W  = IDX_W + 3,
    localparam int CNT_W  = $clog2(NUM_WIN + 1)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_we,
    input  logic [OFF_W-1:0]              cfg_addr,
    input  logic [MW_ADDR_W-1:0]          cfg_wdata,
    output logic [MW_ADDR_W-1:0]          cfg_rdata,
    input  logic [MW_ADDR_W-1:0]          lk_addr,
    output logic                          lk_hit,
    output logic [IDX_W-1:0]              lk_cs,
    output logic [NUM_WIN-1:0]            lk_attr,
    output logic [CNT_W-1:0]              dma_count,
    output logic [NUM_WIN*IDX_W-1:0]      dma_cs,
    output logic [NUM_WIN*MW_ADDR_W-1:0]  dma_base,
    output logic [NUM_WIN*MW_SPAN_W-1:0]  dma_size,
    output logic [NUM_WIN*NUM_WIN-1:0]    dma_attr
);

    win_cfg_t [NUM_WIN-1:0] win;

    memwin_regs #(.NUM_WIN(NUM_WIN)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .win       (win)
    );

    memwin_match #(.NUM_WIN(NUM_WIN)) u_match (
        .win     (win),
        .lk_addr (lk_addr),
        .lk_hit  (lk_hit),
        .lk_cs   (lk_cs),
        .lk_attr (lk_attr)
    );

    memwin_pack #(.NUM_WIN(NUM_WIN)) u_pack (
        .win       (win),
        .dma_count (dma_count),
        .dma_cs    (dma_cs),
        .dma_base  (dma_base),
        .dma_size  (dma_size),
        .dma_attr  (dma_attr)
    );

endmodule

// File: rtl/memwin_chk.sv
module memwin_chk
    import memwin_pkg::*;
#(
    parameter int NUM_WIN = 4,
    localparam int IDX_W  = $clog2(NUM_WIN),
    localparam int OFF_W  = IDX_W + 3,
    localparam int CNT_W  = $clog2(NUM_WIN + 1)
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  cfg_we,
    input logic [OFF_W-1:0]      cfg_addr,
    input logic [MW_ADDR_W-1:0]  cfg_wdata,
    input logic [MW_ADDR_W-1:0]  cfg_rdata,
    input logic                  lk_hit,
    input logic [IDX_W-1:0]      lk_cs,
    input logic [NUM_WIN-1:0]    lk_attr,
    input logic [CNT_W-1:0]      dma_count
);

    // R7
    hit_attr_chk: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> ($countones(lk_attr) == NUM_WIN - 1) && !lk_attr[lk_cs]);

    // R7
    miss_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_cs == '0) && (lk_attr == '0));

    // R3
    undef_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata & ~reg_mask(cfg_addr[2])) == '0);

    // R2
    readback_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (cfg_addr != $past(cfg_addr)) ||
                   (cfg_rdata == ($past(cfg_wdata) & reg_mask($past(cfg_addr[2])))));

    // R8
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        32'(dma_count) <= NUM_WIN);

endmodule

bind memwin_decoder memwin_chk #(.NUM_WIN(NUM_WIN)) u_memwin_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .lk_hit    (lk_hit),
    .lk_cs     (lk_cs),
    .lk_attr   (lk_attr),
    .dma_count (dma_count)
);

// File: tb/test_memwin_decoder.sv
module test_memwin_decoder;

    logic         clk = 1'b0;
    logic         rst;
    logic         cfg_we;
    logic [4:0]   cfg_addr;
    logic [31:0]  cfg_wdata;
    logic [31:0]  cfg_rdata;
    logic [31:0]  lk_addr;
    logic         lk_hit;
    logic [1:0]   lk_cs;
    logic [3:0]   lk_attr;
    logic [2:0]   dma_count;
    logic [7:0]   dma_cs;
    logic [127:0] dma_base;
    logic [131:0] dma_size;
    logic [15:0]  dma_attr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    memwin_decoder i_memwin_decoder (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_addr(lk_addr),
        .lk_hit(lk_hit), .lk_cs(lk_cs), .lk_attr(lk_attr),
        .dma_count(dma_count), .dma_cs(dma_cs), .dma_base(dma_base),
        .dma_size(dma_size), .dma_attr(dma_attr)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; lk_addr = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
        cfg_addr = a;
        #1;
        chk(tag, 64'(cfg_rdata), 64'(exp));
    endtask

    task automatic look(input string tag, input logic [31:0] a,
                        input logic hit, input logic [1:0] cs, input logic [3:0] attr);
        lk_addr = a;
        #1;
        chk({tag, " hit"},  64'(lk_hit),  64'(hit));
        chk({tag, " cs"},   64'(lk_cs),   64'(cs));
        chk({tag, " attr"}, 64'(lk_attr), 64'(attr));
    endtask

    task automatic entry(input string tag, input int k, input logic [1:0] cs,
                         input logic [31:0] base, input logic [32:0] size, input logic [3:0] attr);
        #1;
        chk({tag, " cs"},   64'(dma_cs[k*2 +: 2]),    64'(cs));
        chk({tag, " base"}, 64'(dma_base[k*32 +: 32]), 64'(base));
        chk({tag, " size"}, 64'(dma_size[k*33 +: 33]), 64'(size));
        chk({tag, " attr"}, 64'(dma_attr[k*4 +: 4]),   64'(attr));
    endtask

    // R1: reset state
    task automatic t_reset();
        do_reset();
        for (int a = 0; a < 32; a += 4) rd_chk("R1 reg zero", 5'(a), 32'h0);
        look("R1 no hit", 32'h0000_0000, 1'b0, 2'd0, 4'h0);
        chk("R1 count", 64'(dma_count), 64'd0);
    endtask

    // R2/R3: offsets and stored bits
    task automatic t_regs();
        do_reset();
        wr(5'h10, 32'hFFFF_FFFF);
        wr(5'h14, 32'hFFFF_FFFF);
        rd_chk("R3 base mask", 5'h10, 32'hFF00_000F);
        rd_chk("R3 size mask", 5'h14, 32'hFF00_0001);
        wr(5'h08, 32'h1200_0003);
        rd_chk("R2 win1 base", 5'h08, 32'h1200_0003);
        rd_chk("R2 win0 base untouched", 5'h00, 32'h0);
        rd_chk("R2 win3 size untouched", 5'h1C, 32'h0);
        rd_chk("R2 low bits ignored", 5'h0B, 32'h1200_0003);
    endtask

    // R4/R7/R8/R9/R10: basic map with one high window
    task automatic t_map();
        do_reset();
        wr(5'h00, 32'h0000_0000); wr(5'h04, 32'h0F00_0001);
        wr(5'h08, 32'h1000_0000); wr(5'h0C, 32'h0F00_0001);
        wr(5'h10, 32'h2000_0001); wr(5'h14, 32'h0700_0001);
        wr(5'h18, 32'h4000_0000); wr(5'h1C, 32'h3F00_0001);
        look("R4 win0",      32'h0500_0000, 1'b1, 2'd0, 4'hE);
        look("R4 win1",      32'h1ABC_DEF0, 1'b1, 2'd1, 4'hD);
        look("R10 high win", 32'h2100_0000, 1'b0, 2'd0, 4'h0);
        look("R7 win3",      32'h7FFF_FFFF, 1'b1, 2'd3, 4'h7);
        look("R7 miss",      32'h3000_0000, 1'b0, 2'd0, 4'h0);
        chk("R8 count", 64'(dma_count), 64'd3);
        entry("R9 e0", 0, 2'd0, 32'h0000_0000, 33'h0_1000_0000, 4'hE);
        entry("R9 e1", 1, 2'd1, 32'h1000_0000, 33'h0_1000_0000, 4'hD);
        entry("R8 e2", 2, 2'd3, 32'h4000_0000, 33'h0_4000_0000, 4'h7);
        entry("R9 e3 zero", 3, 2'd0, 32'h0, 33'h0, 4'h0);
    endtask

    // R6/R5: overlap then disable (continues from t_map)
    task automatic t_overlap();
        wr(5'h08, 32'h0000_0000);
        look("R6 lowest wins", 32'h0500_0000, 1'b1, 2'd0, 4'hE);
        wr(5'h04, 32'h0F00_0000);
        look("R5 win0 off", 32'h0500_0000, 1'b1, 2'd1, 4'hD);
        chk("R5 count", 64'(dma_count), 64'd2);
        entry("R5 e0", 0, 2'd1, 32'h0000_0000, 33'h0_1000_0000, 4'hD);
        entry("R5 e1", 1, 2'd3, 32'h4000_0000, 33'h0_4000_0000, 4'h7);
    endtask

    // R9: full 4 GiB window carries into bit 32
    task automatic t_span();
        do_reset();
        wr(5'h14, 32'hFF00_0001);
        chk("R8 single count", 64'(dma_count), 64'd1);
        entry("R9 4GiB", 0, 2'd2, 32'h0, 33'h1_0000_0000, 4'hB);
        look("R4 top addr", 32'hFFFF_FFFF, 1'b1, 2'd2, 4'hB);
        wr(5'h10, 32'h0000_0008);
        look("R10 ext bit3", 32'h0000_0000, 1'b0, 2'd0, 4'h0);
        chk("R10 count", 64'(dma_count), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; lk_addr = '0;
        t_reset();
        t_regs();
        t_map();
        t_overlap();
        t_span();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule